// File: doc/BRIEF.md
# Video memory data port controller

This block is the processor-facing data port of a tile-based video processor's memory interface. It holds a 15-bit video address. A processor write to the address register does not load it at once. The new value waits in a holding register while a programmable countdown runs, and it is committed when the countdown expires. Processor reads and writes of the data port then use that address. Reads are served from a one-byte read-ahead buffer, except in the palette region, where palette data is returned in the same read. Each data access steps the address by 1, or by one tile row (32) when the vertical-step input is set.

The block drives the 14-bit address that the external memory bus carries. This bus address is kept in its own register, apart from the internal video address. Processor-side updates rewrite it only while the `rendering_active` input is low, which means the pins show what the rendering engine owns during active display. Non-palette writes and buffer refills use this bus address. Every real change of the bus address is marked by a one-cycle strobe, so that a cartridge-side counter can watch the address lines for edges.

Address loading is handled by a two-state controller:

- **Idle state (LD_IDLE):** nothing is pending.
- **Countdown state (LD_COUNT):** a value is held and the countdown runs.

The transitions are:

- **Arm:** LD_IDLE goes to LD_COUNT when an address load is requested.
- **Re-arm:** LD_COUNT stays in LD_COUNT when a new load request arrives. The countdown restarts and the old value is discarded.
- **Tick:** LD_COUNT stays in LD_COUNT while the count is above zero, and the count decrements.
- **Commit:** LD_COUNT goes back to LD_IDLE when the count is zero and no new request is present.

Top module: `vdp_data_port`

## Requirements
- R1: After reset, `vram_addr`, `bus_addr` and `cpu_rdata` are 0, `bus_addr_changed` is 0, and the first data-port read returns 0 because the read buffer is cleared.
- R2: A data-port read or write with `rendering_active` low steps `vram_addr` by 32 when `vert_inc` is 1 and by 1 when it is 0. This does not apply when a commit happens in the same cycle (see R11).
- R3: The step wraps modulo 0x8000. After such a step, `bus_addr` equals the new `vram_addr` AND 0x3FFF.
- R4: For a read with `vram_addr[13:0]` below 0x3F00, `cpu_rdata` (valid the cycle after the read) is the byte buffered before the read. The buffer is refilled with `mem_rdata` taken at the `bus_addr` present during the read.
- R5: For a read with `vram_addr[13:0]` at or above 0x3F00, `cpu_rdata` is `{open_bus[7:6], pal_rdata[5:0]}`. The buffer is still refilled as in R4.
- R6: An address load with `load_delay` = d is visible on `vram_addr` exactly d+1 cycles after the request cycle. Before that, `vram_addr` keeps its old value.
- R7: A commit copies the new address AND 0x3FFF onto `bus_addr` only if `rendering_active` is low. Otherwise `bus_addr` is unchanged.
- R8: During a data-port write, `mem_we` is 1 with `mem_waddr` = `bus_addr` when `vram_addr[13:0]` is below 0x3F00. Otherwise `pal_we` is 1. The two are never high together.
- R9: `bus_addr_changed` is 1 in exactly the cycles in which `bus_addr` shows a value different from its previous one. A commit to the same bus value gives no strobe.
- R10: A data access while `rendering_active` is 1 leaves `vram_addr` and `bus_addr` unchanged. A read still returns the buffer and refills it.
- R11: When a commit and a data access fall in the same cycle, the committed address wins and no step is applied. A new load request during a countdown restarts it and discards the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Request to load the video address |
| addr_load_val | input | 15 | Address to load |
| load_delay | input | 4 | Countdown length for the load |
| vert_inc | input | 1 | Step by 32 instead of 1 |
| rendering_active | input | 1 | Rendering owns the bus; processor-side bus updates are blocked |
| cpu_rd | input | 1 | Data-port read strobe |
| cpu_wr | input | 1 | Data-port write strobe |
| cpu_wdata | input | 8 | Data-port write data |
| open_bus | input | 8 | Open-bus latch value |
| pal_rdata | input | 6 | Palette read data at `vram_addr` |
| mem_rdata | input | 8 | Memory read data at `bus_addr` |
| cpu_rdata | output | 8 | Data-port read result |
| vram_addr | output | 15 | Internal video address |
| bus_addr | output | 14 | External memory bus address |
| bus_addr_changed | output | 1 | One-cycle strobe on a bus address change |
| mem_we | output | 1 | Memory write enable at `bus_addr` |
| mem_waddr | output | 14 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| pal_we | output | 1 | Palette write enable at `vram_addr` |

## Verification
The two functions that can land in one cycle are the delayed address commit and a data-port access. The bench provokes the overlap by loading an address with zero delay and issuing a read in the very next cycle. It then judges the outcome:

- `vram_addr` must hold exactly the committed value, not that value plus one.
- The returned byte must be the old buffer contents.
- The refill must come from the bus address that was present before the commit.

A re-arm during a countdown and a commit to the current bus value are also driven. The first must never show the discarded address, and the second must raise no strobe.

// File: rtl/vdp_pkg.sv
package vdp_pkg;
    localparam int ADDR_W   = 15;
    localparam int BUS_W    = ADDR_W - 1;
    localparam int DATA_W   = 8;
    localparam int PAL_W    = 6;
    localparam int ROW_STEP = 32;
    localparam logic [BUS_W-1:0] PAL_BASE = 14'h3F00;

    typedef enum logic {
        LD_IDLE,
        LD_COUNT
    } ld_state_t;
endpackage

// File: rtl/vdp_addr_loader.sv
module vdp_addr_loader
    import vdp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_req,
    input  logic [AW-1:0] load_val,
    input  logic [DW-1:0] load_delay,
    output logic          commit,
    output logic [AW-1:0] commit_addr
);
    ld_state_t     state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic [AW-1:0] pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (load_req) state_d = LD_COUNT;
            LD_COUNT: begin
                if (load_req)          state_d = LD_COUNT;
                else if (cnt_q == '0)  state_d = LD_IDLE;
            end
            default:  state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= '0;
        end else if (load_req) begin
            cnt_q  <= load_delay;
            pend_q <= load_val;
        end else if (state_q == LD_COUNT && cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        commit      = 1'b0;
        commit_addr = pend_q;
        unique case (state_q)
            LD_IDLE:  commit = 1'b0;
            LD_COUNT: commit = (cnt_q == '0) && !load_req;
            default:  commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vdp_addr_unit.sv
module vdp_addr_unit
    import vdp_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int STEP = ROW_STEP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [AW-1:0] commit_addr,
    input  logic          access,
    input  logic          vert_inc,
    input  logic          rendering_active,
    output logic [AW-1:0] vaddr,
    output logic [AW-2:0] bus_addr,
    output logic          bus_changed
);
    localparam int BW = AW - 1;

    logic [AW-1:0] vaddr_d;
    logic [AW-1:0] stride;
    logic          bus_upd;
    logic [BW-1:0] bus_d;

    always_comb begin
        stride  = vert_inc ? AW'(STEP) : AW'(1);
        vaddr_d = vaddr;
        bus_upd = 1'b0;
        if (commit) begin
            vaddr_d = commit_addr;
            bus_upd = !rendering_active;
        end else if (access && !rendering_active) begin
            vaddr_d = vaddr + stride;
            bus_upd = 1'b1;
        end
        bus_d = vaddr_d[BW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr       <= '0;
            bus_addr    <= '0;
            bus_changed <= 1'b0;
        end else begin
            vaddr       <= vaddr_d;
            bus_changed <= bus_upd && (bus_d != bus_addr);
            if (bus_upd) bus_addr <= bus_d;
        end
    end
endmodule

// File: rtl/vdp_read_path.sv
module vdp_read_path
    import vdp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PAL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          pal_sel,
    input  logic [DW-1:0] open_bus,
    input  logic [PW-1:0] pal_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] buf_q;
    logic [DW-1:0] pal_word;

    assign pal_word = {open_bus[DW-1:PW], pal_rdata};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            rdata <= '0;
        end else if (rd) begin
            rdata <= pal_sel ? pal_word : buf_q;
            buf_q <= mem_rdata;
        end
    end
endmodule

// File: rtl/vdp_data_port.sv
module vdp_data_port
    import vdp_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DLYW = 4,
    parameter int DW   = DATA_W,
    parameter int PW   = PAL_W,
    parameter int STEP = ROW_STEP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_load,
    input  logic [AW-1:0]   addr_load_val,
    input  logic [DLYW-1:0] load_delay,
    input  logic            vert_inc,
    input  logic            rendering_active,
    input  logic            cpu_rd,
    input  logic            cpu_wr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic [DW-1:0]   open_bus,
    input  logic [PW-1:0]   pal_rdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   cpu_rdata,
    output logic [AW-1:0]   vram_addr,
    output logic [AW-2:0]   bus_addr,
    output logic            bus_addr_changed,
    output logic            mem_we,
    output logic [AW-2:0]   mem_waddr,
    output logic [DW-1:0]   mem_wdata,
    output logic            pal_we
);
    localparam int BW = AW - 1;

    logic          commit_w;
    logic [AW-1:0] commit_addr_w;
    logic          pal_sel;

    assign pal_sel = (vram_addr[BW-1:0] >= BW'(PAL_BASE));

    vdp_addr_loader #(.AW(AW), .DW(DLYW)) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_req    (addr_load),
        .load_val    (addr_load_val),
        .load_delay  (load_delay),
        .commit      (commit_w),
        .commit_addr (commit_addr_w)
    );

    vdp_addr_unit #(.AW(AW), .STEP(STEP)) u_addr (
        .clk              (clk),
        .rst_n            (rst_n),
        .commit           (commit_w),
        .commit_addr      (commit_addr_w),
        .access           (cpu_rd | cpu_wr),
        .vert_inc         (vert_inc),
        .rendering_active (rendering_active),
        .vaddr            (vram_addr),
        .bus_addr         (bus_addr),
        .bus_changed      (bus_addr_changed)
    );

    vdp_read_path #(.DW(DW), .PW(PW)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (cpu_rd),
        .pal_sel   (pal_sel),
        .open_bus  (open_bus),
        .pal_rdata (pal_rdata),
        .mem_rdata (mem_rdata),
        .rdata     (cpu_rdata)
    );

    assign mem_we    = cpu_wr && !pal_sel;
    assign pal_we    = cpu_wr && pal_sel;
    assign mem_waddr = bus_addr;
    assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/vdp_data_port_chk.sv
module vdp_data_port_chk #(
    parameter int AW   = 15,
    parameter int STEP = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_rd,
    input logic          cpu_wr,
    input logic          vert_inc,
    input logic          rendering_active,
    input logic          commit,
    input logic [AW-1:0] commit_addr,
    input logic [AW-1:0] vram_addr,
    input logic [AW-2:0] bus_addr,
    input logic          bus_addr_changed,
    input logic          mem_we,
    input logic          pal_we
);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && !rendering_active && !commit)
        |=> vram_addr == AW'($past(vram_addr) + ($past(vert_inc) ? AW'(STEP) : AW'(1))));

    assert_commit_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rendering_active) |=> bus_addr == $past(commit_addr[AW-2:0]));

    assert_render_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rendering_active |=> $stable(bus_addr));

    assert_we_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && pal_we));

    assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_changed |-> bus_addr != $past(bus_addr));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr_changed |-> $stable(bus_addr));

    assert_render_noinc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && rendering_active && !commit) |=> $stable(vram_addr));

    assert_commit_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> vram_addr == $past(commit_addr));
endmodule

bind vdp_data_port vdp_data_port_chk #(.AW(AW), .STEP(STEP)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cpu_rd           (cpu_rd),
    .cpu_wr           (cpu_wr),
    .vert_inc         (vert_inc),
    .rendering_active (rendering_active),
    .commit           (commit_w),
    .commit_addr      (commit_addr_w),
    .vram_addr        (vram_addr),
    .bus_addr         (bus_addr),
    .bus_addr_changed (bus_addr_changed),
    .mem_we           (mem_we),
    .pal_we           (pal_we)
);

// File: tb/vdp_data_port_test.sv
module vdp_data_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [14:0] addr_load_val = '0;
    logic [3:0]  load_delay = '0;
    logic        vert_inc = 1'b0;
    logic        rendering_active = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  open_bus = '0;
    logic [5:0]  pal_rdata = '0;
    logic [7:0]  mem_rdata;
    logic [7:0]  cpu_rdata;
    logic [14:0] vram_addr;
    logic [13:0] bus_addr;
    logic        bus_addr_changed;
    logic        mem_we;
    logic [13:0] mem_waddr;
    logic [7:0]  mem_wdata;
    logic        pal_we;

    int checks = 0;
    int errors = 0;

    logic [14:0] exp_v = '0;
    logic [13:0] exp_bus = '0;
    logic [7:0]  exp_buf = '0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [13:0] a);
        return a[7:0] ^ {2'b00, a[13:8]};
    endfunction

    assign mem_rdata = mem_f(bus_addr);

    vdp_data_port uut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_load_val(addr_load_val),
        .load_delay(load_delay), .vert_inc(vert_inc), .rendering_active(rendering_active),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .open_bus(open_bus),
        .pal_rdata(pal_rdata), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
        .vram_addr(vram_addr), .bus_addr(bus_addr), .bus_addr_changed(bus_addr_changed),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .pal_we(pal_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dport(input bit rd, input bit wr);
        logic        pal;
        logic [7:0]  exp_rd;
        logic [13:0] old_bus;
        pal = (exp_v[13:0] >= 14'h3F00);
        open_bus  = ~exp_v[7:0];
        pal_rdata = exp_v[5:0] ^ 6'h2A;
        cpu_wdata = exp_v[7:0] ^ 8'hC3;
        cpu_rd = rd;
        cpu_wr = wr;
        #1;
        if (wr) begin
            chk("R8 mem_we", {31'd0, mem_we}, {31'd0, !pal});
            chk("R8 pal_we", {31'd0, pal_we}, {31'd0, pal});
            if (!pal) chk("R8 mem_waddr", {18'd0, mem_waddr}, {18'd0, exp_bus});
            chk("R8 mem_wdata", {24'd0, mem_wdata}, {24'd0, cpu_wdata});
        end
        exp_rd = pal ? {open_bus[7:6], pal_rdata} : exp_buf;
        old_bus = exp_bus;
        if (rd) exp_buf = mem_f(exp_bus);
        if (!rendering_active) begin
            exp_v = exp_v + (vert_inc ? 15'd32 : 15'd1);
            exp_bus = exp_v[13:0];
        end
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        if (rd) chk(pal ? "R5 palette read" : "R4 buffered read", {24'd0, cpu_rdata}, {24'd0, exp_rd});
        if (rendering_active) begin
            chk("R10 vaddr held", {17'd0, vram_addr}, {17'd0, exp_v});
            chk("R10 bus held", {18'd0, bus_addr}, {18'd0, exp_bus});
        end else begin
            chk("R2 step", {17'd0, vram_addr}, {17'd0, exp_v});
            chk("R3 bus mask", {18'd0, bus_addr}, {18'd0, exp_bus});
        end
        chk("R9 strobe", {31'd0, bus_addr_changed}, {31'd0, old_bus != exp_bus});
    endtask

    task automatic load_addr(input logic [14:0] a, input logic [3:0] d);
        logic [13:0] old_bus;
        logic [14:0] old_v;
        old_bus = exp_bus;
        old_v = exp_v;
        addr_load = 1'b1;
        addr_load_val = a;
        load_delay = d;
        @(negedge clk);
        addr_load = 1'b0;
        for (int k = 0; k <= int'(d); k++) begin
            chk("R6 before commit", {17'd0, vram_addr}, {17'd0, old_v});
            @(negedge clk);
        end
        exp_v = a;
        if (!rendering_active) exp_bus = a[13:0];
        chk("R6 commit", {17'd0, vram_addr}, {17'd0, exp_v});
        chk("R7 bus after commit", {18'd0, bus_addr}, {18'd0, exp_bus});
        chk("R9 commit strobe", {31'd0, bus_addr_changed}, {31'd0, exp_bus != old_bus});
        @(negedge clk);
        chk("R9 strobe one cycle", {31'd0, bus_addr_changed}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset vaddr", {17'd0, vram_addr}, 32'd0);
        chk("R1 reset bus", {18'd0, bus_addr}, 32'd0);
        chk("R1 reset rdata", {24'd0, cpu_rdata}, 32'd0);
        chk("R1 reset strobe", {31'd0, bus_addr_changed}, 32'd0);
        dport(1'b1, 1'b0);
        chk("R1 first read empty buffer", {24'd0, cpu_rdata}, 32'd0);

        // exhaustive unit-step read sweep, wraps through palette and 0x7FFF
        vert_inc = 1'b0;
        for (int i = 0; i < 32768; i++) dport(1'b1, 1'b0);
        chk("R3 wrap back to start", {17'd0, vram_addr}, 32'd1);

        // row-step write sweep over all 1024 row positions
        vert_inc = 1'b1;
        for (int i = 0; i < 1024; i++) dport(1'b0, 1'b1);
        chk("R3 row wrap", {17'd0, vram_addr}, 32'd1);

        // every load delay, alternating rendering
        vert_inc = 1'b0;
        for (int d = 0; d < 16; d++) begin
            rendering_active = d[0];
            load_addr(15'h1000 + 15'(d * 15'h0111), 4'(d));
            if (rendering_active) begin
                dport(1'b0, 1'b1);
                dport(1'b1, 1'b0);
            end
            rendering_active = 1'b0;
            dport(1'b1, 1'b0);
        end

        // commit to the same bus value: no strobe
        load_addr({1'b1, exp_bus}, 4'd2);

        // re-arm during countdown
        exp_v = vram_addr;
        addr_load = 1'b1; addr_load_val = 15'h2AAA; load_delay = 4'd5;
        @(negedge clk);
        addr_load = 1'b0;
        @(negedge clk);
        addr_load = 1'b1; addr_load_val = 15'h0555; load_delay = 4'd1;
        @(negedge clk);
        addr_load = 1'b0;
        chk("R11 restart old value", {17'd0, vram_addr}, {17'd0, exp_v});
        @(negedge clk);
        chk("R11 restart no early", {17'd0, vram_addr}, {17'd0, exp_v});
        @(negedge clk);
        chk("R11 restart new value", {17'd0, vram_addr}, 32'h0555);
        exp_v = 15'h0555; exp_bus = 14'h0555;
        @(negedge clk);
        chk("R11 discarded value never lands", {17'd0, vram_addr}, 32'h0555);

        // commit and read in the same cycle
        dport(1'b1, 1'b0);
        addr_load = 1'b1; addr_load_val = 15'h1234; load_delay = 4'd0;
        @(negedge clk);
        addr_load = 1'b0;
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        chk("R11 collision rdata", {24'd0, cpu_rdata}, {24'd0, exp_buf});
        chk("R11 collision vaddr", {17'd0, vram_addr}, 32'h1234);
        chk("R11 collision bus", {18'd0, bus_addr}, 32'h1234);
        exp_buf = mem_f(exp_bus);
        exp_v = 15'h1234; exp_bus = 14'h1234;
        dport(1'b1, 1'b0);
        chk("R11 collision refill from old bus", {24'd0, cpu_rdata}, {24'd0, mem_f(14'h0556)});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule